// File: doc/BRIEF.md
# Descriptor-Chain Channel Sequencer

This block is a single-channel engine that executes a linked list, or a ring, of work descriptors held in memory. Each descriptor occupies eight 32-bit words. Software stores the address of the first descriptor in the pointer register. It then adds to a counting semaphore. While the count is nonzero, the channel status is clean and the channel is not parked, the engine does the following for each descriptor:

- It fetches the descriptor one word at a time over a simple memory request/response port.
- It hands the source, destination and size to a datapath stub that copies the bytes.
- It writes a completion word back into the descriptor.

Three control bits in each descriptor decide whether the engine decrements the semaphore, whether it raises an interrupt, and whether it follows the next pointer. Malformed descriptors are aborted. Each abort records an error flag or an error code in a sticky status register. The cipher datapath is replaced by the copy stub, which ignores the cipher configuration bits.

Top module: `desc_chan_seq`

## Requirements
- R1: After reset, the pointer, the semaphore count and the status register read 0, irq_o and busy_o are low, and no memory request is issued.
- R2: The register port has four addresses. Address 0 is the pointer, which can be read and written. A write to address 1 adds the written value to the semaphore count, saturating at the all-ones value, and a read of address 1 returns the count. Address 2 is the status register, and any write to it clears it. Address 3 reads as 0.
- R3: While the count is zero, or the status register is nonzero, or the channel is parked, the engine stays idle and issues no memory request. Otherwise it starts fetching at the pointer.
- R4: Descriptor word offsets are: 0 next pointer, 4 control 0, 8 control 1, 12 source, 16 destination, 20 byte size, 24 payload address, 28 status. The engine reads the first seven words in ascending order.
- R5: The stub copies size/4 words, one 32-bit word at a time in ascending order, from the source to the destination. Memory past the last copied word is untouched.
- R6: After a successful copy, the engine writes the value 1 to the descriptor's status word at offset 28.
- R7: On completion, control 0 bit 1 decrements the count by one, and control 0 bit 0 produces a single-cycle pulse on irq_o.
- R8: On completion with control 0 bit 2 set, the engine continues with the descriptor at the next pointer if the count is still nonzero. Otherwise it goes idle with the pointer equal to the next pointer.
- R9: On completion with control 0 bit 2 clear, the engine sets the pointer to the next pointer and parks. It does not resume, even with a nonzero count, until the semaphore register is written again.
- R10: A size that is not a multiple of 16 aborts the descriptor. The abort sets status bit 3 (packet error), copies nothing, writes no status word, pulses irq_o and leaves the pointer at the failing descriptor. The engine then stays halted until status is cleared.
- R11: Control 0 bits 10 and 11 set together abort the descriptor in the same way as R10, but set status bit 2 (setup error).
- R12: A completed descriptor with bit 2 set and a next pointer of 0 writes status code 1 into status bits 23:16 and pulses irq_o once. The pointer stays at that descriptor.
- R13: The cipher configuration bits (control 0 bits 5, 8, 9 and one key-source bit; control 1 bit 4) do not change the data the stub copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| mem_req_o | output | 1 | Memory request, one cycle per access |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| irq_o | output | 1 | Single-cycle interrupt pulse |
| busy_o | output | 1 | Engine is not idle |

## Verification
- **Register writes:** a write takes effect on the clock edge that samples it, and the engine leaves idle on the following edge.
- **Descriptor results:** the copied words, the status word, the pointer and the count are final once busy_o has dropped. The bench therefore waits for busy_o low at a falling edge and then reads memory and registers.
- **Interrupt:** irq_o is a registered pulse one cycle long, so the bench counts it at every falling edge and compares the count before and after each run.
- **Stalls:** the parked and halted cases are checked by holding the semaphore nonzero for tens of cycles and confirming that busy_o and the next descriptor's status word stay unchanged.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
  localparam int WCNT_W = 30;

  localparam logic [1:0] RA_PTR  = 2'd0;
  localparam logic [1:0] RA_SEM  = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  // descriptor word indices fetched by the sequencer
  localparam logic [2:0] W_NEXT = 3'd0;
  localparam logic [2:0] W_CTL0 = 3'd1;
  localparam logic [2:0] W_SRC  = 3'd3;
  localparam logic [2:0] W_DST  = 3'd4;
  localparam logic [2:0] W_SIZE = 3'd5;
  localparam logic [2:0] W_LAST = 3'd6;
  localparam int STAT_OFS = 28;

  localparam int C0_IRQ     = 0;
  localparam int C0_DEC     = 1;
  localparam int C0_CHAIN   = 2;
  localparam int C0_KEY_OTP = 10;
  localparam int C0_KEY_PAY = 11;

  // index into the 6-bit flag field (status bits 6:1)
  localparam int FLG_SETUP  = 1;
  localparam int FLG_PACKET = 2;
  localparam logic [7:0] ERR_NEXT_ZERO = 8'd1;

  typedef enum logic [2:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_CHECK, S_COPY, S_WB, S_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    C_IDLE, C_RD, C_WAIT, C_WR
  } copy_state_e;
endpackage

// File: rtl/dcs_regs.sv
`timescale 1ns/1ps
module dcs_regs
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEM_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [SEM_W-1:0]  sem_o,
  output logic              run_o,
  input  logic              ptr_we_i,
  input  logic [ADDR_W-1:0] ptr_d_i,
  input  logic              sem_dec_i,
  input  logic              park_i,
  input  logic              err_we_i,
  input  logic [7:0]        err_code_i,
  input  logic [5:0]        err_flags_i
);
  localparam logic [SEM_W-1:0] SEM_MAX = '1;

  logic [ADDR_W-1:0] ptr_q;
  logic [SEM_W-1:0]  sem_q, sem_d;
  logic [7:0]        code_q;
  logic [5:0]        flags_q;
  logic              park_q;
  logic              sw_ptr, sw_sem, sw_stat;
  logic [33:0]       sum;

  assign sw_ptr  = reg_we_i && (reg_addr_i == RA_PTR);
  assign sw_sem  = reg_we_i && (reg_addr_i == RA_SEM);
  assign sw_stat = reg_we_i && (reg_addr_i == RA_STAT);

  always_comb begin
    sum = 34'(sem_q) + (sw_sem ? 34'(reg_wdata_i) : 34'd0)
        - (sem_dec_i ? 34'd1 : 34'd0);
    sem_d = (sum > 34'(SEM_MAX)) ? SEM_MAX : sum[SEM_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      sem_q   <= '0;
      code_q  <= '0;
      flags_q <= '0;
      park_q  <= 1'b0;
    end else begin
      if (ptr_we_i)    ptr_q <= ptr_d_i;
      else if (sw_ptr) ptr_q <= reg_wdata_i[ADDR_W-1:0];
      sem_q <= sem_d;
      if (err_we_i) begin
        if (err_code_i != 8'd0) code_q <= err_code_i;
        flags_q <= flags_q | err_flags_i;
      end else if (sw_stat) begin
        code_q  <= '0;
        flags_q <= '0;
      end
      // a semaphore write rearms a parked channel
      if (sw_sem)      park_q <= 1'b0;
      else if (park_i) park_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr_i)
      RA_PTR:  reg_rdata_o = 32'(ptr_q);
      RA_SEM:  reg_rdata_o = 32'(sem_q);
      RA_STAT: reg_rdata_o = {8'd0, code_q, 9'd0, flags_q, 1'b0};
      default: reg_rdata_o = '0;
    endcase
  end

  assign ptr_o = ptr_q;
  assign sem_o = sem_q;
  assign run_o = (sem_q != '0) && (code_q == 8'd0) && (flags_q == 6'd0) && !park_q;

  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sem_dec_i |-> sem_q != '0);
  assert_sem_add_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_sem && !sem_dec_i) |=> sem_q >= $past(sem_q));
  assert_stat_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_stat && !err_we_i) |=> (code_q == 8'd0 && flags_q == 6'd0));
endmodule

// File: rtl/dcs_copy.sv
`timescale 1ns/1ps
module dcs_copy
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [WCNT_W-1:0] nwords_i,
  output logic              done_o,
  output logic              busy_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [31:0]       wdata_o,
  input  logic              rvalid_i,
  input  logic [31:0]       rdata_i
);
  copy_state_e       st_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [WCNT_W-1:0] left_q;
  logic [31:0]       data_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= C_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      left_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        C_IDLE: if (start_i) begin
          if (nwords_i == '0) done_q <= 1'b1;
          else begin
            src_q  <= src_i;
            dst_q  <= dst_i;
            left_q <= nwords_i;
            st_q   <= C_RD;
          end
        end
        C_RD: st_q <= C_WAIT;
        C_WAIT: if (rvalid_i) begin
          data_q <= rdata_i;
          st_q   <= C_WR;
        end
        C_WR: begin
          src_q  <= src_q + ADDR_W'(4);
          dst_q  <= dst_q + ADDR_W'(4);
          left_q <= left_q - 1'b1;
          if (left_q == WCNT_W'(1)) begin
            done_q <= 1'b1;
            st_q   <= C_IDLE;
          end else begin
            st_q <= C_RD;
          end
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assign req_o   = (st_q == C_RD) || (st_q == C_WR);
  assign we_o    = (st_q == C_WR);
  assign addr_o  = (st_q == C_WR) ? dst_q : src_q;
  assign wdata_o = data_q;
  assign done_o  = done_q;
  assign busy_o  = (st_q != C_IDLE);

  assert_start_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> st_q == C_IDLE);
  assert_count_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == C_WR) |-> left_q != '0);
endmodule

// File: rtl/dcs_seq.sv
`timescale 1ns/1ps
module dcs_seq
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEM_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [SEM_W-1:0]  sem_i,
  output logic              ptr_we_o,
  output logic [ADDR_W-1:0] ptr_d_o,
  output logic              sem_dec_o,
  output logic              park_o,
  output logic              err_we_o,
  output logic [7:0]        err_code_o,
  output logic [5:0]        err_flags_o,
  output logic              copy_start_o,
  output logic [ADDR_W-1:0] copy_src_o,
  output logic [ADDR_W-1:0] copy_dst_o,
  output logic [WCNT_W-1:0] copy_nwords_o,
  input  logic              copy_done_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              irq_o,
  output logic              busy_o
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d, next_q, src_q, dst_q;
  logic [31:0]       size_q;
  logic [2:0]        idx_q;
  logic              c_irq_q, c_dec_q, c_chain_q, c_kotp_q, c_kpay_q;
  logic              irq_q, irq_d, load_cur, nz_after;
  logic              bad_size, bad_setup;

  assign bad_size  = (size_q[3:0] != 4'd0);
  assign bad_setup = c_kotp_q && c_kpay_q;
  assign nz_after  = c_dec_q ? (sem_i > SEM_W'(1)) : (sem_i != '0);

  always_comb begin
    state_d      = state_q;
    ptr_we_o     = 1'b0;
    ptr_d_o      = next_q;
    sem_dec_o    = 1'b0;
    park_o       = 1'b0;
    err_we_o     = 1'b0;
    err_code_o   = '0;
    err_flags_o  = '0;
    copy_start_o = 1'b0;
    irq_d        = 1'b0;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = cur_q + ADDR_W'({idx_q, 2'b00});
    mem_wdata_o  = '0;
    load_cur     = 1'b0;
    cur_d        = ptr_i;
    case (state_q)
      S_IDLE: if (run_i) begin
        load_cur = 1'b1;
        state_d  = S_FREQ;
      end
      S_FREQ: begin
        mem_req_o = 1'b1;
        state_d   = S_FWAIT;
      end
      S_FWAIT: if (mem_rvalid_i) state_d = (idx_q == W_LAST) ? S_CHECK : S_FREQ;
      S_CHECK: begin
        if (bad_size || bad_setup) begin
          err_we_o                = 1'b1;
          err_flags_o[FLG_PACKET] = bad_size;
          err_flags_o[FLG_SETUP]  = bad_setup;
          irq_d                   = 1'b1;
          state_d                 = S_IDLE;
        end else begin
          copy_start_o = 1'b1;
          state_d      = S_COPY;
        end
      end
      S_COPY: if (copy_done_i) state_d = S_WB;
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + ADDR_W'(STAT_OFS);
        mem_wdata_o = 32'd1;
        state_d     = S_FIN;
      end
      S_FIN: begin
        sem_dec_o = c_dec_q;
        irq_d     = c_irq_q;
        if (c_chain_q && next_q == '0) begin
          err_we_o   = 1'b1;
          err_code_o = ERR_NEXT_ZERO;
          irq_d      = 1'b1;
          state_d    = S_IDLE;
        end else begin
          ptr_we_o = 1'b1;
          if (c_chain_q && nz_after) begin
            load_cur = 1'b1;
            cur_d    = next_q;
            state_d  = S_FREQ;
          end else begin
            park_o  = !c_chain_q;
            state_d = S_IDLE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cur_q     <= '0;
      idx_q     <= '0;
      next_q    <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      size_q    <= '0;
      c_irq_q   <= 1'b0;
      c_dec_q   <= 1'b0;
      c_chain_q <= 1'b0;
      c_kotp_q  <= 1'b0;
      c_kpay_q  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      if (load_cur) begin
        cur_q <= cur_d;
        idx_q <= '0;
      end else if (state_q == S_FWAIT && mem_rvalid_i) begin
        idx_q <= idx_q + 3'd1;
        case (idx_q)
          W_NEXT: next_q <= mem_rdata_i[ADDR_W-1:0];
          W_CTL0: begin
            c_irq_q   <= mem_rdata_i[C0_IRQ];
            c_dec_q   <= mem_rdata_i[C0_DEC];
            c_chain_q <= mem_rdata_i[C0_CHAIN];
            c_kotp_q  <= mem_rdata_i[C0_KEY_OTP];
            c_kpay_q  <= mem_rdata_i[C0_KEY_PAY];
          end
          W_SRC:   src_q  <= mem_rdata_i[ADDR_W-1:0];
          W_DST:   dst_q  <= mem_rdata_i[ADDR_W-1:0];
          W_SIZE:  size_q <= mem_rdata_i;
          default: ;
        endcase
      end
    end
  end

  assign copy_src_o    = src_q;
  assign copy_dst_o    = dst_q;
  assign copy_nwords_o = size_q[31:2];
  assign irq_o         = irq_q;
  assign busy_o        = (state_q != S_IDLE);

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !run_i) |=> (state_q == S_IDLE && !mem_req_o));
  assert_abort_no_wb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && (bad_size || bad_setup)) |=> (state_q == S_IDLE && !mem_req_o));
  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/desc_chan_seq.sv
`timescale 1ns/1ps
module desc_chan_seq
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEM_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              irq_o,
  output logic              busy_o
);
  logic [ADDR_W-1:0] ptr, ptr_d, c_src, c_dst;
  logic [SEM_W-1:0]  sem;
  logic              run, ptr_we, sem_dec, park, err_we;
  logic [7:0]        err_code;
  logic [5:0]        err_flags;
  logic              c_start, c_done, c_busy;
  logic [WCNT_W-1:0] c_nwords;
  logic              s_req, s_we, k_req, k_we;
  logic [ADDR_W-1:0] s_addr, k_addr;
  logic [31:0]       s_wdata, k_wdata;

  dcs_regs #(.ADDR_W(ADDR_W), .SEM_W(SEM_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .ptr_o(ptr), .sem_o(sem), .run_o(run),
    .ptr_we_i(ptr_we), .ptr_d_i(ptr_d), .sem_dec_i(sem_dec), .park_i(park),
    .err_we_i(err_we), .err_code_i(err_code), .err_flags_i(err_flags)
  );

  dcs_seq #(.ADDR_W(ADDR_W), .SEM_W(SEM_W)) u_seq (
    .clk_i, .rst_ni, .run_i(run), .ptr_i(ptr), .sem_i(sem),
    .ptr_we_o(ptr_we), .ptr_d_o(ptr_d), .sem_dec_o(sem_dec), .park_o(park),
    .err_we_o(err_we), .err_code_o(err_code), .err_flags_o(err_flags),
    .copy_start_o(c_start), .copy_src_o(c_src), .copy_dst_o(c_dst),
    .copy_nwords_o(c_nwords), .copy_done_i(c_done),
    .mem_req_o(s_req), .mem_we_o(s_we), .mem_addr_o(s_addr), .mem_wdata_o(s_wdata),
    .mem_rvalid_i, .mem_rdata_i, .irq_o, .busy_o
  );

  dcs_copy #(.ADDR_W(ADDR_W)) u_copy (
    .clk_i, .rst_ni, .start_i(c_start), .src_i(c_src), .dst_i(c_dst),
    .nwords_i(c_nwords), .done_o(c_done), .busy_o(c_busy),
    .req_o(k_req), .we_o(k_we), .addr_o(k_addr), .wdata_o(k_wdata),
    .rvalid_i(mem_rvalid_i), .rdata_i(mem_rdata_i)
  );

  // the stub owns the port only while it is moving data
  assign mem_req_o   = c_busy ? k_req   : s_req;
  assign mem_we_o    = c_busy ? k_we    : s_we;
  assign mem_addr_o  = c_busy ? k_addr  : s_addr;
  assign mem_wdata_o = c_busy ? k_wdata : s_wdata;

  assert_port_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_busy |-> !s_req);
endmodule

// File: tb/sim_desc_chan_seq.sv
`timescale 1ns/1ps
module sim_desc_chan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        irq, busy;
  logic [31:0] mem [0:1023];
  int n_chk = 0, n_fail = 0, irq_cnt = 0;

  desc_chan_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .irq_o(irq), .busy_o(busy)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[11:2]];
      end
    end
  end

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put_desc(input int base, input logic [31:0] nxt, input logic [31:0] c0,
                          input logic [31:0] c1, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] size);
    mem[(base >> 2) + 0] = nxt;
    mem[(base >> 2) + 1] = c0;
    mem[(base >> 2) + 2] = c1;
    mem[(base >> 2) + 3] = src;
    mem[(base >> 2) + 4] = dst;
    mem[(base >> 2) + 5] = size;
    mem[(base >> 2) + 6] = 32'h0;
    mem[(base >> 2) + 7] = 32'h0;
  endtask

  function automatic logic [31:0] pat(input int seed, input int i);
    return 32'hA5000000 ^ (seed << 16) ^ (i * 32'h01010101);
  endfunction

  task automatic fill(input int addr, input int n, input int seed);
    for (int i = 0; i < n; i++) mem[(addr >> 2) + i] = pat(seed, i);
  endtask

  initial begin
    logic [31:0] v;
    int irq0;

    // reset state
    reset_dut();
    rd(2'd0, v); chk("R1 ptr", v, 32'h0);
    rd(2'd1, v); chk("R1 sem", v, 32'h0);
    rd(2'd2, v); chk("R1 status", v, 32'h0);
    chk("R1 busy", {31'd0, busy}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'h0);
    wr(2'd0, 32'h0000_0344);
    rd(2'd0, v); chk("R2 ptr readback", v, 32'h344);
    rd(2'd3, v); chk("R2 addr3 zero", v, 32'h0);
    repeat (20) @(negedge clk);
    chk("R3 idle with zero count", {31'd0, busy}, 32'h0);

    // single descriptor sweep over sizes, cipher bits alternating
    for (int k = 0; k < 5; k++) begin
      logic [31:0] c0, c1;
      reset_dut();
      c0 = (k % 2 == 1) ? 32'h0000_0723 : 32'h0000_0803;
      c1 = (k % 2 == 1) ? 32'h10 : 32'h0;
      put_desc(32'h100, 32'h180, c0, c1, 32'h400, 32'h800, 32'(k * 16));
      fill(32'h400, 20, k);
      for (int i = 0; i < 20; i++) mem[(32'h800 >> 2) + i] = 32'hDEAD_BEEF;
      wr(2'd0, 32'h100);
      irq0 = irq_cnt;
      wr(2'd1, 32'd1);
      settle();
      for (int i = 0; i < k * 4; i++)
        chk($sformatf("R5 R13 copy k=%0d w=%0d", k, i), mem[(32'h800 >> 2) + i], pat(k, i));
      chk("R5 tail untouched", mem[(32'h800 >> 2) + k * 4], 32'hDEAD_BEEF);
      chk("R6 status word", mem[(32'h100 >> 2) + 7], 32'h1);
      rd(2'd1, v); chk("R7 sem decremented", v, 32'h0);
      chk("R7 one irq", 32'(irq_cnt - irq0), 32'h1);
      rd(2'd0, v); chk("R9 ptr to next", v, 32'h180);
      rd(2'd2, v); chk("R4 clean status", v, 32'h0);
    end

    // chained ring of three descriptors
    reset_dut();
    put_desc(32'h100, 32'h120, 32'h7, 32'h0, 32'h400, 32'h900, 32'd16);
    put_desc(32'h120, 32'h140, 32'h6, 32'h0, 32'h440, 32'h980, 32'd32);
    put_desc(32'h140, 32'h100, 32'h7, 32'h0, 32'h480, 32'hA00, 32'd16);
    fill(32'h400, 48, 7);
    wr(2'd0, 32'h100);
    irq0 = irq_cnt;
    wr(2'd1, 32'd2);
    settle();
    chk("R8 d0 done", mem[(32'h100 >> 2) + 7], 32'h1);
    chk("R8 d1 done", mem[(32'h120 >> 2) + 7], 32'h1);
    chk("R8 d2 not run", mem[(32'h140 >> 2) + 7], 32'h0);
    for (int i = 0; i < 8; i++)
      chk("R5 d1 copy", mem[(32'h980 >> 2) + i], pat(7, 16 + i));
    rd(2'd0, v); chk("R8 ptr at d2", v, 32'h140);
    rd(2'd1, v); chk("R8 sem zero", v, 32'h0);
    chk("R7 irq only d0", 32'(irq_cnt - irq0), 32'h1);
    irq0 = irq_cnt;
    wr(2'd1, 32'd1);
    settle();
    chk("R8 d2 done", mem[(32'h140 >> 2) + 7], 32'h1);
    chk("R5 d2 copy", mem[(32'hA00 >> 2) + 3], pat(7, 32 + 3));
    rd(2'd0, v); chk("R8 ptr wraps", v, 32'h100);
    chk("R7 irq d2", 32'(irq_cnt - irq0), 32'h1);

    // unchained stop parks the channel
    reset_dut();
    put_desc(32'h100, 32'h140, 32'h1, 32'h0, 32'h400, 32'h900, 32'd16);
    put_desc(32'h140, 32'h100, 32'h0, 32'h0, 32'h400, 32'h980, 32'd16);
    wr(2'd0, 32'h100);
    irq0 = irq_cnt;
    wr(2'd1, 32'd2);
    settle();
    repeat (40) @(negedge clk);
    rd(2'd1, v); chk("R2 R9 sem kept", v, 32'h2);
    rd(2'd0, v); chk("R9 ptr next", v, 32'h140);
    chk("R9 next not run", mem[(32'h140 >> 2) + 7], 32'h0);
    chk("R9 parked", {31'd0, busy}, 32'h0);
    chk("R9 irq", 32'(irq_cnt - irq0), 32'h1);
    wr(2'd1, 32'd0);
    settle();
    chk("R9 rearm runs next", mem[(32'h140 >> 2) + 7], 32'h1);
    rd(2'd0, v); chk("R9 ptr after rearm", v, 32'h100);

    // bad size
    reset_dut();
    put_desc(32'h100, 32'h140, 32'h3, 32'h0, 32'h400, 32'h900, 32'd20);
    fill(32'h400, 8, 3);
    mem[32'h900 >> 2] = 32'hDEAD_BEEF;
    wr(2'd0, 32'h100);
    irq0 = irq_cnt;
    wr(2'd1, 32'd1);
    settle();
    repeat (30) @(negedge clk);
    rd(2'd2, v); chk("R10 packet flag", v, 32'h8);
    chk("R10 no status wb", mem[(32'h100 >> 2) + 7], 32'h0);
    chk("R10 no copy", mem[32'h900 >> 2], 32'hDEAD_BEEF);
    rd(2'd0, v); chk("R10 ptr stays", v, 32'h100);
    rd(2'd1, v); chk("R10 sem kept", v, 32'h1);
    chk("R10 irq", 32'(irq_cnt - irq0), 32'h1);
    chk("R10 halted", {31'd0, busy}, 32'h0);
    mem[(32'h100 >> 2) + 5] = 32'd16;
    wr(2'd2, 32'h0);
    settle();
    rd(2'd2, v); chk("R10 cleared", v, 32'h0);
    chk("R10 resumed wb", mem[(32'h100 >> 2) + 7], 32'h1);
    chk("R10 resumed copy", mem[32'h900 >> 2], pat(3, 0));

    // conflicting key sources
    reset_dut();
    put_desc(32'h100, 32'h140, 32'hC03, 32'h0, 32'h400, 32'h900, 32'd16);
    wr(2'd0, 32'h100);
    irq0 = irq_cnt;
    wr(2'd1, 32'd1);
    settle();
    rd(2'd2, v); chk("R11 setup flag", v, 32'h4);
    chk("R11 no status wb", mem[(32'h100 >> 2) + 7], 32'h0);
    chk("R11 irq", 32'(irq_cnt - irq0), 32'h1);

    // chain to a null pointer
    reset_dut();
    put_desc(32'h100, 32'h0, 32'h7, 32'h0, 32'h400, 32'h900, 32'd16);
    wr(2'd0, 32'h100);
    irq0 = irq_cnt;
    wr(2'd1, 32'd3);
    settle();
    chk("R12 desc done", mem[(32'h100 >> 2) + 7], 32'h1);
    rd(2'd2, v); chk("R12 code 1", v, 32'h0001_0000);
    rd(2'd0, v); chk("R12 ptr stays", v, 32'h100);
    rd(2'd1, v); chk("R12 sem", v, 32'h2);
    chk("R12 single irq", 32'(irq_cnt - irq0), 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule